// File: doc/BRIEF.md
# Flagless Variable Shift Unit

This execution unit shifts a source operand by an amount taken from a second register. It performs one of three shifts: arithmetic right, logical left or logical right. The operation is chosen by a two-bit code that stands for the instruction's mandatory prefix. The operand size is 64 bits only when the wide-operand bit is set and the code segment runs in 64-bit mode. In every other case the unit shifts 32 bits, and the shift count is masked to match the operand size.

The unit never reads or writes any condition flag. Encodings that are not allowed raise an undefined-opcode exception and produce no write. These are a nonzero vector-length bit, real mode and virtual-8086 mode. A prefix code that does not name one of the three shifts leaves both the write-enable and the exception low.

The result comes from a logarithmic barrel shifter and is registered. The destination value, write-enable and exception appear one clock after the operands are presented. The caller presents one operation per cycle.

Top module: `shx_unit`

## Requirements
- R1: The prefix code selects the operation. Code 2'b10 is an arithmetic right shift, 2'b01 is a logical left shift and 2'b11 is a logical right shift. Code 2'b00 is not this instruction: it gives no write and no exception.
- R2: The operand size is 64 bits when wBit and seg64 are both 1, and 32 bits otherwise. In particular, wBit has no effect when seg64 is 0.
- R3: The effective count is cntVal[5:0] at 64-bit size and cntVal[4:0] at 32-bit size. All higher count bits are ignored.
- R4: The arithmetic right shift fills vacated high positions with the operand's sign bit. That is bit 63 at 64-bit size and bit 31 at 32-bit size.
- R5: The logical right shift fills vacated high bits with zero, and the left shift fills vacated low bits with zero.
- R6: At 32-bit size, only srcVal[31:0] is shifted and destVal[63:32] is zero.
- R7: An effective count of zero returns the operand unchanged. At 32-bit size the result is the zero-extended low half.
- R8: When lBit is 1 for a recognised prefix code, udExc is asserted and destWe is held low.
- R9: When realMode or v86Mode is 1 for a recognised prefix code, udExc is asserted and destWe is held low.
- R10: The outputs register the operation presented in the previous cycle. Reset clears destVal, destWe and udExc to zero, and destVal is zero in any cycle without a write.
- R11: destWe and udExc are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcVal | input | 64 | Operand to be shifted |
| cntVal | input | 64 | Shift count register value |
| pfxCode | input | 2 | Operation code: 00 none, 01 left, 10 arithmetic right, 11 logical right |
| wBit | input | 1 | Wide-operand request |
| lBit | input | 1 | Vector-length bit, must be 0 |
| seg64 | input | 1 | Code segment in 64-bit mode |
| realMode | input | 1 | Processor in real mode |
| v86Mode | input | 1 | Processor in virtual-8086 mode |
| destVal | output | 64 | Shift result |
| destWe | output | 1 | Destination write-enable |
| udExc | output | 1 | Undefined-opcode exception |

## Verification
On every cycle the assertions check four things. The exception and the write are mutually exclusive. Illegal lengths or modes raise the exception one cycle later, and an unrecognised code stays silent. A 32-bit result leaves the upper half clear, and a zero count passes the operand through. The shifted values themselves are shown only by the bench's scenarios, which compare them with a behavioural model. These scenarios cover sign fill at both sizes, count masking with high bits set, the largest counts, and a set wBit outside 64-bit mode.

// File: rtl/shx_pkg.sv
package shx_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SHL  = 2'b01,
    OP_SAR  = 2'b10,
    OP_SHR  = 2'b11
  } shxOp_e;

  typedef struct packed {
    logic   wrEn;
    logic   udRaise;
    logic   wide;
    shxOp_e op;
  } shxCtrl_t;

endpackage

// File: rtl/shx_ctrl.sv
module shx_ctrl
  import shx_pkg::*;
(
  input  logic [1:0] pfxCode,
  input  logic       wBit,
  input  logic       lBit,
  input  logic       seg64,
  input  logic       realMode,
  input  logic       v86Mode,
  output shxCtrl_t   ctrl
);

  logic isShift;
  logic badEnc;

  always_comb begin
    isShift      = (pfxCode != 2'b00);
    badEnc       = lBit | realMode | v86Mode;
    ctrl.op      = shxOp_e'(pfxCode);
    ctrl.wide    = wBit & seg64;
    ctrl.udRaise = isShift & badEnc;
    ctrl.wrEn    = isShift & ~badEnc;
  end

endmodule

// File: rtl/shx_dp.sv
module shx_dp
  import shx_pkg::*;
#(
  parameter int DW = 64,
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  shxCtrl_t      ctrl,
  input  logic [DW-1:0] srcVal,
  input  logic [DW-1:0] cntVal,
  output logic [DW-1:0] destVal,
  output logic          destWe,
  output logic          udExc
);

  localparam int SW  = $clog2(DW);
  localparam int NSW = $clog2(NW);

  logic [SW-1:0]        shAmt;
  logic                 fillBit;
  logic                 goLeft;
  logic [DW-1:0]        opnd;
  logic [SW:0][DW-1:0]  stg;
  logic [DW-1:0]        res;

  always_comb begin
    shAmt   = ctrl.wide ? cntVal[SW-1:0]
                        : {{(SW-NSW){1'b0}}, cntVal[NSW-1:0]};
    fillBit = (ctrl.op == OP_SAR) & (ctrl.wide ? srcVal[DW-1] : srcVal[NW-1]);
    goLeft  = (ctrl.op == OP_SHL);
    opnd    = ctrl.wide ? srcVal : {{(DW-NW){fillBit}}, srcVal[NW-1:0]};
  end

  assign stg[0] = opnd;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [DW-1:0] fillMask;
    assign fillMask = fillBit ? ~({DW{1'b1}} >> STEP) : '0;
    assign stg[k+1] = !shAmt[k] ? stg[k]
                    : goLeft    ? (stg[k] << STEP)
                                : ((stg[k] >> STEP) | fillMask);
  end

  always_comb begin
    res = ctrl.wide ? stg[SW] : {{(DW-NW){1'b0}}, stg[SW][NW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      destVal <= '0;
      destWe  <= 1'b0;
      udExc   <= 1'b0;
    end else begin
      destVal <= ctrl.wrEn ? res : '0;
      destWe  <= ctrl.wrEn;
      udExc   <= ctrl.udRaise;
    end
  end

endmodule

// File: rtl/shx_unit.sv
module shx_unit
  import shx_pkg::*;
#(
  parameter int DW = 64,
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] srcVal,
  input  logic [DW-1:0] cntVal,
  input  logic [1:0]    pfxCode,
  input  logic          wBit,
  input  logic          lBit,
  input  logic          seg64,
  input  logic          realMode,
  input  logic          v86Mode,
  output logic [DW-1:0] destVal,
  output logic          destWe,
  output logic          udExc
);

  shxCtrl_t ctrl;

  shx_ctrl u_ctrl (
    .pfxCode (pfxCode),
    .wBit    (wBit),
    .lBit    (lBit),
    .seg64   (seg64),
    .realMode(realMode),
    .v86Mode (v86Mode),
    .ctrl    (ctrl)
  );

  shx_dp #(.DW(DW), .NW(NW)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .srcVal (srcVal),
    .cntVal (cntVal),
    .destVal(destVal),
    .destWe (destWe),
    .udExc  (udExc)
  );

endmodule

// File: rtl/shx_unit_chk.sv
module shx_unit_chk #(
  parameter int DW = 64,
  parameter int NW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic [DW-1:0] srcVal,
  input logic [DW-1:0] cntVal,
  input logic [1:0]    pfxCode,
  input logic          wBit,
  input logic          lBit,
  input logic          seg64,
  input logic          realMode,
  input logic          v86Mode,
  input logic [DW-1:0] destVal,
  input logic          destWe,
  input logic          udExc
);

  localparam int SW  = $clog2(DW);
  localparam int NSW = $clog2(NW);

  logic legalOp;
  logic wideOp;
  assign legalOp = (pfxCode != 2'b00) && !lBit && !realMode && !v86Mode;
  assign wideOp  = wBit && seg64;

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(destWe && udExc));

  assert_ud_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pfxCode != 2'b00 && lBit) |=> (udExc && !destWe));

  assert_ud_mode_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pfxCode != 2'b00 && (realMode || v86Mode)) |=> (udExc && !destWe));

  assert_silent_R1: assert property (@(posedge clk) disable iff (!rstN)
    (pfxCode == 2'b00) |=> (!destWe && !udExc));

  assert_upper_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pfxCode != 2'b00 && !wideOp) |=> (destVal[DW-1:NW] == '0));

  assert_pass_wide_R7: assert property (@(posedge clk) disable iff (!rstN)
    (legalOp && wideOp && cntVal[SW-1:0] == '0) |=> (destVal == $past(srcVal)));

  assert_pass_narrow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (legalOp && !wideOp && cntVal[NSW-1:0] == '0)
      |=> (destVal[NW-1:0] == $past(srcVal[NW-1:0])));

endmodule

bind shx_unit shx_unit_chk #(.DW(DW), .NW(NW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .srcVal  (srcVal),
  .cntVal  (cntVal),
  .pfxCode (pfxCode),
  .wBit    (wBit),
  .lBit    (lBit),
  .seg64   (seg64),
  .realMode(realMode),
  .v86Mode (v86Mode),
  .destVal (destVal),
  .destWe  (destWe),
  .udExc   (udExc)
);

// File: tb/sim_shx_unit.sv
`timescale 1ns/1ps
module sim_shx_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] srcVal, cntVal;
  logic [1:0]  pfxCode;
  logic        wBit, lBit, seg64, realMode, v86Mode;
  logic [63:0] destVal;
  logic        destWe, udExc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  shx_unit u0 (
    .clk(clk), .rstN(rstN), .srcVal(srcVal), .cntVal(cntVal),
    .pfxCode(pfxCode), .wBit(wBit), .lBit(lBit), .seg64(seg64),
    .realMode(realMode), .v86Mode(v86Mode),
    .destVal(destVal), .destWe(destWe), .udExc(udExc)
  );

  function automatic logic [63:0] model(input logic [63:0] s, input logic [63:0] c,
                                        input logic [1:0] p, input logic wide);
    int n;
    logic [31:0] lo;
    n  = wide ? int'(c & 64'h3F) : int'(c & 64'h1F);
    lo = s[31:0];
    if (wide) begin
      case (p)
        2'b10:   return $signed(s) >>> n;
        2'b01:   return s << n;
        2'b11:   return s >> n;
        default: return '0;
      endcase
    end else begin
      case (p)
        2'b10:   return {32'h0, 32'($signed(lo) >>> n)};
        2'b01:   return {32'h0, lo << n};
        2'b11:   return {32'h0, lo >> n};
        default: return '0;
      endcase
    end
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input string req, input logic [63:0] s, input logic [63:0] c,
                       input logic [1:0] p, input logic w, input logic l,
                       input logic sg, input logic rm, input logic vm);
    logic known, bad;
    logic [63:0] expV;
    @(negedge clk);
    srcVal = s; cntVal = c; pfxCode = p; wBit = w; lBit = l;
    seg64 = sg; realMode = rm; v86Mode = vm;
    @(posedge clk);
    @(negedge clk);
    known = (p != 2'b00);
    bad   = l | rm | vm;
    expV  = (known && !bad) ? model(s, c, p, w & sg) : '0;
    check(req, "destWe", {63'h0, destWe}, {63'h0, known && !bad});
    check(req, "udExc",  {63'h0, udExc},  {63'h0, known && bad});
    check(req, "destVal", destVal, expV);
  endtask

  task automatic tReset();
    @(negedge clk);
    check("R10", "reset destVal", destVal, '0);
    check("R10", "reset destWe", {63'h0, destWe}, '0);
    check("R10", "reset udExc", {63'h0, udExc}, '0);
  endtask

  task automatic tWideOps();
    runOp("R4", 64'h8000_0000_0000_1234, 64'd4, 2'b10, 1, 0, 1, 0, 0);
    runOp("R4", 64'h7F00_0000_0000_0000, 64'd8, 2'b10, 1, 0, 1, 0, 0);
    runOp("R5", 64'hF000_0000_0000_00FF, 64'd12, 2'b11, 1, 0, 1, 0, 0);
    runOp("R5", 64'h8000_0000_0000_00FF, 64'd60, 2'b01, 1, 0, 1, 0, 0);
    runOp("R1", 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 2'b10, 1, 0, 1, 0, 0);
    runOp("R1", 64'hFFFF_FFFF_FFFF_FFFF, 64'd63, 2'b11, 1, 0, 1, 0, 0);
  endtask

  task automatic tNarrowOps();
    runOp("R6", 64'hDEAD_BEEF_8000_0010, 64'd4, 2'b10, 1, 0, 0, 0, 0);
    runOp("R6", 64'hDEAD_BEEF_F000_0001, 64'd31, 2'b01, 0, 0, 1, 0, 0);
    runOp("R4", 64'h0000_0000_8765_4321, 64'd31, 2'b10, 0, 0, 1, 0, 0);
    runOp("R5", 64'hFFFF_FFFF_8765_4321, 64'd16, 2'b11, 0, 0, 1, 0, 0);
    runOp("R2", 64'h8000_0000_0000_0000, 64'd32, 2'b11, 1, 0, 0, 0, 0);
  endtask

  task automatic tCountMask();
    runOp("R3", 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF45, 2'b10, 1, 0, 1, 0, 0);
    runOp("R3", 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0025, 2'b10, 0, 0, 1, 0, 0);
    runOp("R3", 64'h1,                   64'h0000_0001_0000_0040, 2'b01, 1, 0, 1, 0, 0);
    runOp("R7", 64'hCAFE_F00D_1234_5678, 64'h20, 2'b01, 0, 0, 1, 0, 0);
    runOp("R7", 64'hCAFE_F00D_1234_5678, 64'h0,  2'b10, 1, 0, 1, 0, 0);
  endtask

  task automatic tIllegal();
    runOp("R8", 64'h1234, 64'd1, 2'b01, 1, 1, 1, 0, 0);
    runOp("R9", 64'h1234, 64'd1, 2'b11, 0, 0, 0, 1, 0);
    runOp("R9", 64'h1234, 64'd1, 2'b10, 0, 0, 0, 0, 1);
    runOp("R1", 64'h1234, 64'd1, 2'b00, 1, 0, 1, 0, 0);
    runOp("R11", 64'h1234, 64'd1, 2'b00, 0, 1, 0, 1, 1);
    runOp("R10", 64'h00F0, 64'd4, 2'b11, 1, 0, 1, 0, 0);
  endtask

  initial begin
    rstN = 1'b0; srcVal = '0; cntVal = '0; pfxCode = '0;
    wBit = 0; lBit = 0; seg64 = 0; realMode = 0; v86Mode = 0;
    repeat (3) @(posedge clk);
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    tWideOps();
    tNarrowOps();
    tCountMask();
    tIllegal();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule